// File: doc/BRIEF.md
# SDRAM Mode Register Command Unit

This block sits on the device side of an SDRAM interface. On every rising clock edge it samples the command pins, the clock-enable pin, the two bank-select bits and the address bus. When it sees a legal load-mode command, it stores the address word into the main mode register or into the extended mode register. For the main register it also decodes burst length, burst ordering, CAS latency, test mode and the DLL reset request into registered outputs.

A load-mode command is only honoured when three things hold: every bank reports idle, clock-enable has been high long enough, and no earlier register write is still in progress. An accepted write opens a two-cycle window. During that window only NOP or deselect is allowed; anything else is discarded and flagged. Every rejected command raises a one-cycle violation pulse. The stored words change only through accepted writes.

Top module: `sdr_mode_unit`

## Requirements
- R1: A command is a load-mode command when cs_n, ras_n, cas_n and we_n are all sampled low. With bank bits 2'b00, an accepted load-mode command stores addr into mr_word at the edge that samples it.
- R2: A load-mode command with bank bits 2'b01, when accepted, stores addr into emr_word. It leaves mr_word, the decoded fields and configured unchanged. A load-mode command with bank bit 1 set is ignored and raises violation.
- R3: A load-mode command sampled while banks_idle is low is ignored and raises violation.
- R4: A load-mode command is accepted only if cke is high at the sampling edge and was also high at the edge before it. Otherwise it is ignored and raises violation.
- R5: After an accepted write, busy is high for exactly two cycles. A command sampled in those two edges that is neither NOP (cs_n low, ras_n/cas_n/we_n high) nor deselect (cs_n high) is ignored and raises violation.
- R6: mr_word and emr_word keep their values until the next accepted write to the same register. Other commands, outside the window, neither change them nor raise violation.
- R7: addr[2:0] sets burst_len: 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8. Any other code gives 0 and sets bl_reserved.
- R8: burst_interleave equals addr[3] of the last accepted main write (0 sequential, 1 interleaved).
- R9: addr[6:4] sets cas_latency: 3'b011 gives 3, 3'b100 gives 4, 3'b101 gives 5. Any other code gives 0 and sets cl_reserved.
- R10: test_mode equals addr[7] of the last accepted main write (1 means vendor test mode).
- R11: If addr[8] was set in an accepted main write, dll_reset_pulse is high for exactly one cycle, following the second edge after the write's sampling edge. It stays low otherwise.
- R12: After reset: mr_word and emr_word are zero, configured is low, busy and violation are low, and the decoded outputs are those of an all-zero word (bl_reserved and cl_reserved high). configured rises on the first accepted main write and never falls.
- R13: violation is a registered one-cycle pulse, raised at the edge that samples the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank-select bits, choose target register |
| addr | input | 12 | Address bus carrying the mode word |
| banks_idle | input | 1 | High when all banks are idle |
| mr_word | output | 12 | Stored main mode word |
| emr_word | output | 12 | Stored extended mode word |
| burst_len | output | 4 | Decoded burst length (0 if reserved) |
| burst_interleave | output | 1 | Burst ordering, 1 = interleaved |
| cas_latency | output | 3 | Decoded CAS latency (0 if reserved) |
| bl_reserved | output | 1 | Burst-length code is reserved |
| cl_reserved | output | 1 | CAS-latency code is reserved |
| test_mode | output | 1 | Vendor test mode selected |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| configured | output | 1 | A main write has been accepted since reset |
| busy | output | 1 | Register write window in progress |
| violation | output | 1 | One-cycle pulse on a rejected command |

## Verification
The assertions assume the pins hold a defined level at every rising edge. They also assume reset is held for at least one edge, so that the CKE history begins from a known low. The stimulus changes inputs only on falling edges and keeps them constant across each rising edge. Reset is held with cke low, and the CKE rule is then exercised on purpose. All 4096 address words are swept through accepted main writes, each separated by the two-cycle window. Every non-NOP pin pattern is injected into the window.

// File: rtl/sdr_mode_pkg.sv
package sdr_mode_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL    = 2'd0,
        CMD_NOP      = 2'd1,
        CMD_LOADMODE = 2'd2,
        CMD_OTHER    = 2'd3
    } sdr_cmd_e;

    localparam logic [1:0] TGT_MAIN = 2'b00;
    localparam logic [1:0] TGT_EXT  = 2'b01;

    typedef struct packed {
        logic [3:0] burst_len;
        logic       bl_rsvd;
        logic       interleave;
        logic [2:0] cas_lat;
        logic       cl_rsvd;
        logic       test_mode;
        logic       dll_req;
    } mode_fields_t;

    function automatic mode_fields_t decode_mode(input logic [8:0] w);
        mode_fields_t f;
        f = '0;
        case (w[2:0])
            3'b001:  f.burst_len = 4'd2;
            3'b010:  f.burst_len = 4'd4;
            3'b011:  f.burst_len = 4'd8;
            default: f.bl_rsvd   = 1'b1;
        endcase
        f.interleave = w[3];
        case (w[6:4])
            3'b011:  f.cas_lat = 3'd3;
            3'b100:  f.cas_lat = 3'd4;
            3'b101:  f.cas_lat = 3'd5;
            default: f.cl_rsvd = 1'b1;
        endcase
        f.test_mode = w[7];
        f.dll_req   = w[8];
        return f;
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_mode_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdr_cmd_e cmd
);
    always_comb begin
        if (cs_n)
            cmd = CMD_DESEL;
        else if ({ras_n, cas_n, we_n} == 3'b111)
            cmd = CMD_NOP;
        else if ({ras_n, cas_n, we_n} == 3'b000)
            cmd = CMD_LOADMODE;
        else
            cmd = CMD_OTHER;
    end
endmodule

// File: rtl/sdr_mr_guard.sv
module sdr_mr_guard
    import sdr_mode_pkg::*;
#(
    parameter int WR_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  sdr_cmd_e cmd,
    input  logic     cke,
    input  logic [1:0] ba,
    input  logic     banks_idle,
    output logic     mr_we,
    output logic     emr_we,
    output logic     finishing,
    output logic     busy,
    output logic     violation
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] win_cnt;
    logic             cke_prev;
    logic             in_win;
    logic             load_ok;
    logic             bad;

    assign in_win    = (win_cnt != '0);
    assign finishing = (win_cnt == CNT_W'(1));
    assign busy      = in_win;

    always_comb begin
        load_ok = 1'b0;
        bad     = 1'b0;
        if (in_win) begin
            bad = (cmd != CMD_NOP) && (cmd != CMD_DESEL);
        end else if (cmd == CMD_LOADMODE) begin
            load_ok = banks_idle && cke && cke_prev && !ba[1];
            bad     = !load_ok;
        end
    end

    assign mr_we  = load_ok && (ba == TGT_MAIN);
    assign emr_we = load_ok && (ba == TGT_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt   <= '0;
            cke_prev  <= 1'b0;
            violation <= 1'b0;
        end else begin
            cke_prev  <= cke;
            violation <= bad;
            if (load_ok)
                win_cnt <= CNT_W'(WR_CYCLES);
            else if (in_win)
                win_cnt <= win_cnt - 1'b1;
        end
    end

    // R4
    cke_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_we || emr_we) |-> (cke && $past(cke)));

    // R5
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        mr_we |=> busy ##1 busy ##1 !busy);

    // R5
    no_write_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(mr_we || emr_we));

    // R13
    viol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NOP && !busy) |=> !violation);
endmodule

// File: rtl/sdr_mr_store.sv
module sdr_mr_store
    import sdr_mode_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mr_we,
    input  logic              emr_we,
    input  logic              finishing,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] mr_word,
    output logic [ADDR_W-1:0] emr_word,
    output mode_fields_t      fields,
    output logic              configured,
    output logic              dll_pulse
);
    logic dll_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mr_word    <= '0;
            emr_word   <= '0;
            fields     <= decode_mode(9'd0);
            configured <= 1'b0;
            dll_pend   <= 1'b0;
            dll_pulse  <= 1'b0;
        end else begin
            dll_pulse <= finishing && dll_pend;
            if (mr_we) begin
                mr_word    <= addr;
                fields     <= decode_mode(addr[8:0]);
                configured <= 1'b1;
                dll_pend   <= addr[8];
            end else if (emr_we) begin
                emr_word <= addr;
                dll_pend <= 1'b0;
            end
        end
    end

    // R6
    mr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(mr_we) |-> $stable(mr_word));

    // R12
    configured_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        configured |=> configured);

    // R11
    dll_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        dll_pulse |=> !dll_pulse);

    // R7
    bl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(fields.burst_len) <= 1);
endmodule

// File: rtl/sdr_mode_unit.sv
module sdr_mode_unit
    import sdr_mode_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WR_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              banks_idle,
    output logic [ADDR_W-1:0] mr_word,
    output logic [ADDR_W-1:0] emr_word,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic [2:0]        cas_latency,
    output logic              bl_reserved,
    output logic              cl_reserved,
    output logic              test_mode,
    output logic              dll_reset_pulse,
    output logic              configured,
    output logic              busy,
    output logic              violation
);
    sdr_cmd_e     cmd;
    logic         mr_we;
    logic         emr_we;
    logic         finishing;
    mode_fields_t fields;

    sdr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdr_mr_guard #(.WR_CYCLES(WR_CYCLES)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .cke        (cke),
        .ba         (ba),
        .banks_idle (banks_idle),
        .mr_we      (mr_we),
        .emr_we     (emr_we),
        .finishing  (finishing),
        .busy       (busy),
        .violation  (violation)
    );

    sdr_mr_store #(.ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .mr_we      (mr_we),
        .emr_we     (emr_we),
        .finishing  (finishing),
        .addr       (addr),
        .mr_word    (mr_word),
        .emr_word   (emr_word),
        .fields     (fields),
        .configured (configured),
        .dll_pulse  (dll_reset_pulse)
    );

    assign burst_len        = fields.burst_len;
    assign burst_interleave = fields.interleave;
    assign cas_latency      = fields.cas_lat;
    assign bl_reserved      = fields.bl_rsvd;
    assign cl_reserved      = fields.cl_rsvd;
    assign test_mode        = fields.test_mode;

    // R3
    idle_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_we || emr_we) |-> banks_idle);

    // R2
    emr_no_touch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(emr_we) |-> $stable(mr_word) && $stable(configured));
endmodule

// File: tb/sdr_mode_unit_tb.sv
module sdr_mode_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cke, cs_n, ras_n, cas_n, we_n, banks_idle;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [11:0] mr_word, emr_word;
    logic [3:0]  burst_len;
    logic        burst_interleave;
    logic [2:0]  cas_latency;
    logic        bl_reserved, cl_reserved, test_mode;
    logic        dll_reset_pulse, configured, busy, violation;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    sdr_mode_unit u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .banks_idle(banks_idle), .mr_word(mr_word), .emr_word(emr_word),
        .burst_len(burst_len), .burst_interleave(burst_interleave),
        .cas_latency(cas_latency), .bl_reserved(bl_reserved),
        .cl_reserved(cl_reserved), .test_mode(test_mode),
        .dll_reset_pulse(dll_reset_pulse), .configured(configured),
        .busy(busy), .violation(violation)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // apply pins at falling edge, return at next falling edge
    task automatic cmd(input logic c, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [11:0] a);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        @(negedge clk);
    endtask

    task automatic nop();
        cmd(1'b0, 3'b111, 2'b00, 12'h000);
    endtask

    task automatic load(input logic [1:0] b, input logic [11:0] a);
        cmd(1'b0, 3'b000, b, a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        rst = 1'b1; cke = 1'b0; banks_idle = 1'b1;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        ba = 2'b00; addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 mr_word", mr_word, 0);
        chk("R12 emr_word", emr_word, 0);
        chk("R12 configured", configured, 0);
        chk("R12 busy", busy, 0);
        chk("R12 violation", violation, 0);
        chk("R12 bl_reserved", bl_reserved, 1);
        chk("R12 cl_reserved", cl_reserved, 1);
        chk("R12 burst_len", burst_len, 0);

        // R4: cke rises in the same cycle as the command
        cke = 1'b1;
        load(2'b00, 12'h132);
        chk("R4 violation", violation, 1);
        chk("R4 mr_word", mr_word, 0);
        chk("R4 busy", busy, 0);
        nop();
        chk("R13 violation one cycle", violation, 0);

        // R2 extended register first
        load(2'b01, 12'h5A5);
        chk("R2 emr_word", emr_word, 12'h5A5);
        chk("R2 mr_word untouched", mr_word, 0);
        chk("R2 configured untouched", configured, 0);
        chk("R2 violation", violation, 0);
        chk("R5 busy after ext", busy, 1);
        nop(); nop();
        chk("R11 no dll after ext", dll_reset_pulse, 0);
        chk("R5 busy ends", busy, 0);

        // R2 reserved bank targets
        load(2'b10, 12'h0FF);
        chk("R2 reserved target violation", violation, 1);
        chk("R2 reserved target emr", emr_word, 12'h5A5);
        chk("R2 reserved target mr", mr_word, 0);
        load(2'b11, 12'h0FF);
        chk("R2 reserved target violation", violation, 1);
        chk("R2 reserved target busy", busy, 0);

        // R3 banks not idle
        banks_idle = 1'b0;
        load(2'b00, 12'h132);
        chk("R3 violation", violation, 1);
        chk("R3 mr_word", mr_word, 0);
        chk("R3 configured", configured, 0);
        banks_idle = 1'b1;

        // R4 cke drop for one cycle
        cke = 1'b0; nop(); cke = 1'b1;
        load(2'b00, 12'h132);
        chk("R4 after drop violation", violation, 1);
        chk("R4 after drop mr_word", mr_word, 0);
        nop();

        // sweep every main word: R1 R6 R7 R8 R9 R10 R11 R12
        for (int a = 0; a < 4096; a++) begin
            int c, d, ebl, ecl;
            c = a & 7; d = (a >> 4) & 7;
            ebl = (c >= 1 && c <= 3) ? (1 << c) : 0;
            ecl = (d >= 3 && d <= 5) ? d : 0;
            load(2'b00, 12'(a));
            chk("R1 mr_word", mr_word, a);
            chk("R13 no violation", violation, 0);
            chk("R12 configured", configured, 1);
            chk("R7 burst_len", burst_len, ebl);
            chk("R7 bl_reserved", bl_reserved, (ebl == 0) ? 1 : 0);
            chk("R8 interleave", burst_interleave, (a >> 3) & 1);
            chk("R9 cas_latency", cas_latency, ecl);
            chk("R9 cl_reserved", cl_reserved, (ecl == 0) ? 1 : 0);
            chk("R10 test_mode", test_mode, (a >> 7) & 1);
            chk("R2 emr held", emr_word, 12'h5A5);
            nop();
            chk("R5 busy 2nd", busy, 1);
            chk("R11 dll early", dll_reset_pulse, 0);
            nop();
            chk("R5 busy done", busy, 0);
            chk("R11 dll pulse", dll_reset_pulse, (a >> 8) & 1);
            nop();
            chk("R11 dll one cycle", dll_reset_pulse, 0);
        end

        // R5 every non-NOP pattern in each window slot
        for (int slot = 0; slot < 2; slot++) begin
            for (int p = 0; p < 7; p++) begin
                load(2'b00, 12'h132);
                if (slot == 1) nop();
                cmd(1'b0, 3'(p), 2'b00, 12'h0A3);
                chk("R5 window violation", violation, 1);
                chk("R5 window mr held", mr_word, 12'h132);
                chk("R5 window emr held", emr_word, 12'h5A5);
                if (slot == 0) nop();
                chk("R5 window closes", busy, 0);
                nop();
            end
        end
        // R5 deselect in window is fine
        load(2'b00, 12'h022);
        cmd(1'b1, 3'b000, 2'b00, 12'h0FF);
        chk("R5 deselect ok", violation, 0);
        chk("R5 deselect mr", mr_word, 12'h022);
        nop(); nop();

        // R6 other commands outside window
        for (int p = 1; p < 7; p++) begin
            cmd(1'b0, 3'(p), 2'(p & 3), 12'hFFF);
            chk("R6 no violation", violation, 0);
            chk("R6 mr held", mr_word, 12'h022);
            chk("R6 emr held", emr_word, 12'h5A5);
        end

        finish_run();
    end
endmodule